// File: doc/BRIEF.md
# Limit Compare Interrupt Controller

This block watches a set of hardware-monitor readings and turns limit violations into interrupts. Seven unsigned voltage readings are each compared against their own low and high limits. A signed temperature reading is compared against a high limit and a hysteresis threshold. Fan alarms, an external thermal input, a RAM overflow event and a chassis-intrusion input complete the event set. The readings come from an external converter, and `sample_valid` marks a cycle in which a fresh set of readings is present.

Every event sets a bit in one of two 8-bit status registers. A status register clears when it is read, which is a one-cycle `rd_en` strobe with a register select. Each status bit then passes through two separate mask sets. One set drives the SMI output. The other drives a single NMI/IRQ path, and a configuration bit chooses which of the two pins that path uses. A configuration register holds the monitor enable, the two output enables, an interrupt clear and the NMI/IRQ select. The mask and configuration registers are written with a `wr_en` strobe, `wr_sel` and `wr_data`.

Write selects: 0 = configuration, 1 = SMI mask 1, 2 = SMI mask 2, 3 = NMI/IRQ mask 1, 4 = NMI/IRQ mask 2. Read selects: 0 = status 1, 1 = status 2. `rd_data` always shows the selected status register. The clear happens only on the clock edge where `rd_en` is high. After reset, configuration and status are 0 and all mask bits are 1.

Top module: `lci_limit_irq`

## Requirements
- R1: With monitoring on, a sampled voltage above its high limit sets its status bit on the same clock edge. Channels 0..3 use status-1 bits 0..3, and channels 4..6 use status-2 bits 0..2.
- R2: A sampled voltage below its low limit sets the same status bit as in R1.
- R3: A high limit of 0xFF never produces a high-side event for that channel. A high limit of 0xFE still does.
- R4: Temperature is compared as two's complement. In hysteresis mode, a sample above the high limit while not already hot sets status-1 bit 4 once. Later samples that stay above the limit do not set it again.
- R5: In hysteresis mode, once hot, a sample below the hysteresis threshold sets status-1 bit 4 again. Samples between the hysteresis threshold and the high limit set nothing.
- R6: When the hysteresis threshold is 127, every sample above the high limit sets status-1 bit 4.
- R7: A read strobe returns the register value and clears its non-sticky bits on that edge. An event on the same edge stays pending. Both status registers are 0 after reset.
- R8: Configuration bit 0 enables monitoring. While it is 0, samples, fan alarms and the thermal input set no status bit.
- R9: An output fires when a status bit is set and the matching bit of that output's mask register is 0. Status-2 bits 6 and 7 never drive an output. With all mask bits 1, the outputs stay low.
- R10: Configuration bit 1 enables SMI, and bit 2 enables the NMI/IRQ path. Bit 5 steers that path to `nmi_o` when 1 and to `irq_o` when 0. The two pins are never high together.
- R11: Configuration bit 3 forces all three interrupt outputs low while it is set.
- R12: Chassis intrusion latches into status-2 bit 4. A read does not clear it. Only a write to NMI/IRQ mask 2 with data bit 7 set clears it, and that bit is not stored in the mask.
- R13: Event map: fan 1 → status-1 bit 6, fan 2 → status-1 bit 7, thermal input → status-1 bit 5, fan 3 → status-2 bit 3, RAM overflow → status-2 bit 5 (accepted even with monitoring off). Status-2 bit 6 is set on the edge after the cycle in which `smi_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Fresh readings present this cycle |
| volt_val | input | 56 | Seven 8-bit voltage readings, channel 0 in the low byte |
| volt_hi | input | 56 | Seven high limits |
| volt_lo | input | 56 | Seven low limits |
| temp_val | input | 8 | Temperature reading, two's complement |
| temp_hi | input | 8 | Temperature high limit, two's complement |
| temp_hyst | input | 8 | Hysteresis threshold; 127 selects level mode |
| fan_alarm | input | 3 | Fan slow alarms, fans 1..3 |
| therm_in | input | 1 | External thermal event |
| ram_ovf | input | 1 | RAM overflow event |
| chassis_in | input | 1 | Chassis intrusion event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe (clears on read) |
| rd_sel | input | 1 | Status register select |
| rd_data | output | 8 | Selected status register |
| smi_o | output | 1 | SMI interrupt |
| nmi_o | output | 1 | NMI interrupt |
| irq_o | output | 1 | IRQ interrupt |

## Verification
The voltage comparators are driven with values above the window, below the window, inside it, and at the 0xFF ceiling. This separates high-side, low-side and disabled-high behaviour, and it confirms the mapping of channels to status bits. The temperature path is driven with a rising-then-falling sequence through the limits in hysteresis mode, with a value between the two thresholds, with limits where signed and unsigned ordering disagree, and with repeated hot samples in level mode. Interrupt routing is checked by opening one mask bit at a time, flipping the NMI/IRQ select and asserting the clear bit. Chassis latching is checked against reads and against mask writes with and without bit 7 set.

// File: rtl/lci_pkg.sv
package lci_pkg;
  localparam int REGW    = 8;
  localparam int NUM_VIN = 7;
  localparam int VIN_R1  = 4;  // channels kept in status register 1

  localparam logic [2:0] SEL_CFG  = 3'd0;
  localparam logic [2:0] SEL_SMI1 = 3'd1;
  localparam logic [2:0] SEL_SMI2 = 3'd2;
  localparam logic [2:0] SEL_NMI1 = 3'd3;
  localparam logic [2:0] SEL_NMI2 = 3'd4;

  // configuration bit positions
  localparam int CFG_MON   = 0;
  localparam int CFG_SMIEN = 1;
  localparam int CFG_NIEN  = 2;
  localparam int CFG_CLR   = 3;
  localparam int CFG_NSEL  = 5;

  // status 2: chassis bit is sticky; bits 6,7 never feed outputs
  localparam logic [REGW-1:0] ST2_STICKY  = 8'h10;
  localparam logic [REGW-1:0] ST2_OUT_SRC = 8'h3F;

  function automatic logic outside_window(input logic [7:0] v, input logic [7:0] hi,
                                          input logic [7:0] lo);
    return ((hi != 8'hFF) && (v > hi)) || (v < lo);
  endfunction

  function automatic logic s_greater(input logic signed [7:0] a, input logic signed [7:0] b);
    return a > b;
  endfunction
endpackage

// File: rtl/lci_volt_cmp.sv
module lci_volt_cmp #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [VW-1:0] val,
  input  logic [VW-1:0] hi,
  input  logic [VW-1:0] lo,
  output logic          ev
);
  import lci_pkg::*;

  assign ev = sample & outside_window(val, hi, lo);

  // R3: saturated high limit with value not under low limit never trips
  p_ff_disables_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi == '1 && val >= lo) |-> !ev);
endmodule

// File: rtl/lci_temp_track.sv
module lci_temp_track #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [TW-1:0] t_val,
  input  logic [TW-1:0] t_hi,
  input  logic [TW-1:0] t_hyst,
  output logic          ev
);
  import lci_pkg::*;
  localparam logic [TW-1:0] LEVEL_CODE = {1'b0, {(TW-1){1'b1}}};

  logic hot_q;
  logic level_mode, above, below;

  assign level_mode = (t_hyst == LEVEL_CODE);
  assign above      = s_greater(t_val, t_hi);
  assign below      = s_greater(t_hyst, t_val);

  always_comb begin
    if (!sample)         ev = 1'b0;
    else if (level_mode) ev = above;
    else if (hot_q)      ev = below;
    else                 ev = above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else if (sample) begin
      if (level_mode || !hot_q) hot_q <= above;
      else                      hot_q <= !below;
    end
  end

  // R6: level mode reports every hot sample
  p_level_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && t_hyst == LEVEL_CODE && $signed(t_val) > $signed(t_hi)) |-> ev);
  // R5: between thresholds in hysteresis mode nothing fires
  p_quiet_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_hyst != LEVEL_CODE && $signed(t_val) <= $signed(t_hi) &&
     $signed(t_val) >= $signed(t_hyst)) |-> !ev);
  // R4: a second hot sample in a row does not fire again
  p_no_refire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && t_hyst != LEVEL_CODE && $signed(t_val) > $signed(t_hi) && ev) |=>
    ((sample && t_hyst != LEVEL_CODE && $signed(t_val) > $signed(t_hi) &&
      $signed(t_val) >= $signed(t_hyst)) |-> !ev));
endmodule

// File: rtl/lci_status_reg.sv
module lci_status_reg #(
  parameter int            W      = 8,
  parameter logic [W-1:0]  STICKY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         rd_clr,
  input  logic [W-1:0] sticky_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] keep;

  always_comb begin
    keep = rd_clr ? (q & STICKY) : q;
    keep = keep & ~(sticky_clr & STICKY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= keep | ev;
  end

  // R7: events are never lost, even on a read edge
  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(ev)) == $past(ev)));
  // R7: a read leaves only fresh events in non-sticky bits
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((q & ~STICKY) == ($past(ev) & ~STICKY)));
  // R12: sticky bits survive unless explicitly cleared
  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(q & STICKY & ~sticky_clr)) == $past(q & STICKY & ~sticky_clr)));
endmodule

// File: rtl/lci_limit_irq.sv
module lci_limit_irq #(
  parameter int VW = 8,
  parameter int TW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_valid,
  input  logic [lci_pkg::NUM_VIN*VW-1:0] volt_val,
  input  logic [lci_pkg::NUM_VIN*VW-1:0] volt_hi,
  input  logic [lci_pkg::NUM_VIN*VW-1:0] volt_lo,
  input  logic [TW-1:0]                 temp_val,
  input  logic [TW-1:0]                 temp_hi,
  input  logic [TW-1:0]                 temp_hyst,
  input  logic [2:0]                    fan_alarm,
  input  logic                          therm_in,
  input  logic                          ram_ovf,
  input  logic                          chassis_in,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic [lci_pkg::REGW-1:0]      wr_data,
  input  logic                          rd_en,
  input  logic                          rd_sel,
  output logic [lci_pkg::REGW-1:0]      rd_data,
  output logic                          smi_o,
  output logic                          nmi_o,
  output logic                          irq_o
);
  import lci_pkg::*;
  localparam int NV_R2 = NUM_VIN - VIN_R1;

  logic [REGW-1:0] cfg_q, smi_m1, smi_m2, nmi_m1, nmi_m2;
  logic [REGW-1:0] st1, st2, ev1, ev2, chas_clr;
  logic [NUM_VIN-1:0] volt_ev;
  logic mon_on, smp, temp_ev, smi_hit, nmi_hit, gate_ok, chas_wr;

  assign mon_on = cfg_q[CFG_MON];
  assign smp    = sample_valid & mon_on;

  for (genvar g = 0; g < NUM_VIN; g++) begin : g_vin
    lci_volt_cmp #(.VW(VW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .sample(smp),
      .val(volt_val[g*VW +: VW]), .hi(volt_hi[g*VW +: VW]), .lo(volt_lo[g*VW +: VW]),
      .ev(volt_ev[g]));
  end

  lci_temp_track #(.TW(TW)) u_temp (
    .clk(clk), .rst_n(rst_n), .sample(smp), .t_val(temp_val),
    .t_hi(temp_hi), .t_hyst(temp_hyst), .ev(temp_ev));

  // named event vectors for the assertions
  assign ev1 = {fan_alarm[1] & mon_on, fan_alarm[0] & mon_on, therm_in & mon_on,
                temp_ev, volt_ev[VIN_R1-1:0]};
  assign ev2 = {1'b0, smi_o, ram_ovf, chassis_in, fan_alarm[2] & mon_on,
                volt_ev[NUM_VIN-1 -: NV_R2]};

  assign chas_wr  = wr_en && (wr_sel == SEL_NMI2) && wr_data[7];
  assign chas_clr = chas_wr ? ST2_STICKY : '0;

  lci_status_reg #(.W(REGW), .STICKY('0)) u_st1 (
    .clk(clk), .rst_n(rst_n), .ev(ev1), .rd_clr(rd_en & ~rd_sel),
    .sticky_clr('0), .q(st1));

  lci_status_reg #(.W(REGW), .STICKY(ST2_STICKY)) u_st2 (
    .clk(clk), .rst_n(rst_n), .ev(ev2), .rd_clr(rd_en & rd_sel),
    .sticky_clr(chas_clr), .q(st2));

  assign rd_data = rd_sel ? st2 : st1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      smi_m1 <= '1;
      smi_m2 <= '1;
      nmi_m1 <= '1;
      nmi_m2 <= 8'h7F;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CFG:  cfg_q  <= wr_data;
        SEL_SMI1: smi_m1 <= wr_data;
        SEL_SMI2: smi_m2 <= wr_data;
        SEL_NMI1: nmi_m1 <= wr_data;
        SEL_NMI2: nmi_m2 <= {1'b0, wr_data[REGW-2:0]};
        default:  ;
      endcase
    end
  end

  assign smi_hit = |(st1 & ~smi_m1) | |(st2 & ST2_OUT_SRC & ~smi_m2);
  assign nmi_hit = |(st1 & ~nmi_m1) | |(st2 & ST2_OUT_SRC & ~nmi_m2);
  assign gate_ok = ~cfg_q[CFG_CLR];

  assign smi_o = gate_ok & cfg_q[CFG_SMIEN] & smi_hit;
  assign nmi_o = gate_ok & cfg_q[CFG_NIEN] &  cfg_q[CFG_NSEL] & nmi_hit;
  assign irq_o = gate_ok & cfg_q[CFG_NIEN] & ~cfg_q[CFG_NSEL] & nmi_hit;

  // R10: shared path drives one pin only
  p_nmi_irq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_o && irq_o));
  // R11: interrupt clear silences everything
  p_clear_quiets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CFG_CLR] |-> !(smi_o || nmi_o || irq_o));
  // R9: fully masked SMI set never fires
  p_masked_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_m1 == '1 && smi_m2 == '1) |-> !smi_o);
  // R13: an asserted SMI is logged in status 2
  p_smi_logged_r13: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |=> st2[6]);
  // R8: monitoring off leaves status 1 untouched
  p_mon_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_on |-> (ev1 == '0));
endmodule

// File: tb/sim_lci_limit_irq.sv
module sim_lci_limit_irq;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, sample_valid, therm_in, ram_ovf, chassis_in, wr_en, rd_en, rd_sel;
  logic [55:0] volt_val, volt_hi, volt_lo;
  logic [7:0] temp_val, temp_hi, temp_hyst, wr_data, rd_data;
  logic [2:0] fan_alarm, wr_sel;
  logic smi_o, nmi_o, irq_o;
  logic [7:0] vv [7];
  logic [7:0] vh [7];
  logic [7:0] vl [7];

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      volt_val[i*8 +: 8] = vv[i];
      volt_hi[i*8 +: 8]  = vh[i];
      volt_lo[i*8 +: 8]  = vl[i];
    end
  end

  lci_limit_irq u0 (.*);

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  // monitor: pops expected items and compares to the ports
  initial begin
    forever begin
      item_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      begin
        logic [7:0] act;
        act = (it.kind == 0) ? rd_data : {5'b0, smi_o, nmi_o, irq_o};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #1;
  endtask

  task automatic peek(logic sel, logic [7:0] exp, string tag);
    rd_sel = sel; #1; push(0, exp, tag);
  endtask

  task automatic outs(logic [2:0] exp, string tag);  // {smi,nmi,irq}
    push(1, {5'b0, exp}, tag);
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd(logic sel, logic [7:0] exp, string tag);
    rd_sel = sel; rd_en = 1; #1; push(0, exp, tag); tick(); rd_en = 0;
  endtask

  task automatic sample();
    sample_valid = 1; tick(); sample_valid = 0;
  endtask

  // bench view of a window violation
  function automatic logic viol(logic [7:0] v, logic [7:0] h, logic [7:0] l);
    return (h != 8'hFF && v > h) || (v < l);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sample_valid = 0; therm_in = 0; ram_ovf = 0; chassis_in = 0;
    wr_en = 0; rd_en = 0; rd_sel = 0; wr_sel = 0; wr_data = 0; fan_alarm = 0;
    for (int i = 0; i < 7; i++) begin vv[i] = 8'h80; vh[i] = 8'hC0; vl[i] = 8'h40; end
    temp_val = 8'd20; temp_hi = 8'd50; temp_hyst = 8'd40;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    peek(0, 8'h00, "R7 reset status1");
    peek(1, 8'h00, "R7 reset status2");
    outs(3'b000, "R9 reset outputs");

    vv[0] = 8'hD0; sample();
    peek(0, 8'h00, "R8 monitor off");
    fan_alarm = 3'b111; therm_in = 1; tick(); fan_alarm = 0; therm_in = 0;
    peek(0, 8'h00, "R8 fans ignored");

    wr(3'd0, 8'h01);
    sample();
    peek(0, {7'b0, viol(vv[0], vh[0], vl[0])}, "R1 ch0 high");
    rd(0, 8'h01, "R7 read value");
    peek(0, 8'h00, "R7 cleared");

    vv[0] = 8'h80; vv[5] = 8'h10; sample();
    peek(1, 8'h02, "R2 ch5 low");
    rd(1, 8'h02, "R2 read");
    vv[5] = 8'h80; vv[6] = 8'hF0; sample();
    peek(1, 8'h04, "R1 ch6 high");
    rd(1, 8'h04, "R1 read"); vv[6] = 8'h80;

    vh[3] = 8'hFF; vv[3] = 8'hFF; sample();
    peek(0, 8'h00, "R3 ff disables");
    vh[3] = 8'hFE; sample();
    peek(0, 8'h08, "R3 fe still trips");
    rd(0, 8'h08, "R3 read"); vh[3] = 8'hC0; vv[3] = 8'h80;

    temp_val = 8'd60; sample();
    peek(0, 8'h10, "R4 rise above");
    rd(0, 8'h10, "R4 read");
    temp_val = 8'd70; sample();
    peek(0, 8'h00, "R4 no refire");
    temp_val = 8'd45; sample();
    peek(0, 8'h00, "R5 band quiet");
    temp_val = 8'd30; sample();
    peek(0, 8'h10, "R5 fall below");
    rd(0, 8'h10, "R5 read");

    temp_hi = 8'hF6; temp_hyst = 8'hEC; temp_val = 8'h05; sample();
    peek(0, 8'h10, "R4 signed above");
    rd(0, 8'h10, "R4 signed read");
    temp_val = 8'hE2; sample();
    peek(0, 8'h10, "R5 signed below");
    rd(0, 8'h10, "R5 signed read");

    temp_hi = 8'd50; temp_hyst = 8'h7F; temp_val = 8'd60; sample();
    peek(0, 8'h10, "R6 level first");
    rd(0, 8'h10, "R6 read");
    sample();
    peek(0, 8'h10, "R6 level repeat");
    rd(0, 8'h10, "R6 read 2");
    temp_val = 8'd20; sample();
    peek(0, 8'h00, "R6 level cool");

    vv[0] = 8'hD0; sample(); vv[0] = 8'h80; vv[1] = 8'hD0;
    sample_valid = 1; rd(0, 8'h01, "R7 read with event"); sample_valid = 0;
    peek(0, 8'h02, "R7 event kept");
    rd(0, 8'h02, "R7 read kept"); vv[1] = 8'h80;

    fan_alarm = 3'b111; therm_in = 1; ram_ovf = 1; tick();
    fan_alarm = 0; therm_in = 0; ram_ovf = 0;
    peek(0, 8'hE0, "R13 fans therm");
    peek(1, 8'h28, "R13 fan3 ramovf");
    rd(0, 8'hE0, "R13 read1"); rd(1, 8'h28, "R13 read2");

    vv[0] = 8'hD0; sample(); vv[0] = 8'h80;
    wr(3'd0, 8'h07);
    outs(3'b000, "R9 all masked");
    wr(3'd1, 8'hFE);
    outs(3'b100, "R9 smi unmasked");
    tick();
    peek(1, 8'h40, "R13 smi logged");
    wr(3'd3, 8'hFE);
    outs(3'b101, "R10 irq selected");
    wr(3'd0, 8'h27);
    outs(3'b110, "R10 nmi selected");
    wr(3'd0, 8'h2F);
    outs(3'b000, "R11 clear bit");
    wr(3'd0, 8'h23);
    outs(3'b100, "R10 nmi disabled");
    wr(3'd0, 8'h27);
    rd(0, 8'h01, "R9 read source");
    outs(3'b000, "R9 source gone");
    rd(1, 8'h40, "R13 read smi bit");
    peek(1, 8'h00, "R13 smi bit cleared");

    chassis_in = 1; tick(); chassis_in = 0;
    peek(1, 8'h10, "R12 latched");
    rd(1, 8'h10, "R12 read");
    peek(1, 8'h10, "R12 survives read");
    wr(3'd4, 8'h00);
    peek(1, 8'h10, "R12 survives plain write");
    outs(3'b010, "R9 chassis via nmi mask2");
    wr(3'd4, 8'h80);
    peek(1, 8'h00, "R12 cleared by bit7");
    outs(3'b000, "R12 outputs quiet");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule